// File: doc/BRIEF.md
# Register Specifier Decoder with Extension Prefix

This block turns the register-selecting parts of an instruction into full register numbers and an address-form summary. Its inputs are an optional extension prefix byte, a flag for the operand-size override prefix (66h), a flag for byte-sized operations, the 3-bit register field of the opcode, the ModRM byte, and the index and base bits of the SIB byte. Each result is 4 bits wide: the prefix supplies the top bit and the instruction field supplies the low three. This gives sixteen registers in 64-bit mode.

The block also classifies the memory operand. It reports whether a SIB byte follows, whether the address is relative to the instruction pointer, whether there is a base register, whether there is an index register, and how large the displacement is. The special encodings are tested on the low three field bits only, so the extension bit never hides them. The one exception is the SIB "no index" code, which does take the extension bit into account.

The decoder is used one instruction per cycle by a decode stage that has already found the prefix and ModRM bytes. All results are registered, and `out_valid` marks the cycle in which they apply.

Top module: `regspec_decoder`

## Requirements
- R1: The results appear one clock cycle after `in_valid` is sampled high, with `out_valid` set. When `in_valid` is low, `out_valid` is low in the next cycle. A synchronous reset clears `out_valid` and every result output to zero.
- R2: A prefix byte is taken as the extension prefix only when `long_mode`, `pfx_present` and a high nibble of 4h (bytes 40h to 4Fh) are all true. Its bit 3 is W, bit 2 is R, bit 1 is X and bit 0 is B. In every other case, W, R, X and B are all zero.
- R3: `op_size` uses the codes 0 = 8 bits, 1 = 16 bits, 2 = 32 bits and 3 = 64 bits. A byte operation gives 0. Otherwise, W=1 gives 3 even when `opsz_ovr` is set, `opsz_ovr` with W=0 gives 1, and the default is 2.
- R4: `reg_num` is {R, modrm[5:3]} and `opc_num` is {B, opc_reg}.
- R5: For mod = 11 (register form), `rm_num` is {B, modrm[2:0]}. In this form `sib_present`, `rip_rel`, `base_num` and `index_num` are 0, `no_base` and `no_index` are 1, and `disp_size` is 0.
- R6: For mod other than 11 with modrm[2:0] = 100, `sib_present` is 1 whatever the value of B. The base is then {B, sib_base}.
- R7: The SIB index number is {X, sib_index}. It means "no index" (`no_index` = 1) only when that number is 0100, that is, only when X = 0. With X = 1 and sib_index = 100, the index is register 12.
- R8: mod = 00 with modrm[2:0] = 101 gives `no_base` = 1 and `disp_size` = 2, whatever the value of B. In long mode `rip_rel` = 1; outside long mode `rip_rel` = 0.
- R9: With a SIB byte, mod = 00 and sib_base = 101, `no_base` = 1 and `disp_size` = 2, whatever the value of B. With mod = 01 or 10, the same base bits name register {B, 101}.
- R10: `disp_size` uses the codes 0 = none, 1 = 8 bits and 2 = 32 bits. mod = 01 gives 1 and mod = 10 gives 2. mod = 00 gives 0 except in the cases of R8 and R9.
- R11: When `no_base` is 1, `base_num` is 0. When `no_index` is 1, `index_num` is 0. Memory forms without a SIB byte report `no_index` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | The input fields are valid this cycle |
| long_mode | input | 1 | 64-bit mode is active |
| pfx_present | input | 1 | A candidate prefix byte is present |
| pfx_byte | input | 8 | Candidate extension prefix byte |
| opsz_ovr | input | 1 | An operand-size override prefix (66h) is present |
| byte_op | input | 1 | The instruction operates on bytes |
| opc_reg | input | 3 | Register field of the opcode byte |
| modrm | input | 8 | ModRM byte |
| sib_lo | input | 6 | SIB bits 5:0 (index in 5:3, base in 2:0) |
| out_valid | output | 1 | The results below are valid |
| reg_num | output | 4 | Register number from the reg field |
| rm_num | output | 4 | Register number from the r/m field |
| base_num | output | 4 | Base register number |
| index_num | output | 4 | Index register number |
| opc_num | output | 4 | Register number from the opcode field |
| op_size | output | 2 | Effective operand size code |
| sib_present | output | 1 | A SIB byte follows ModRM |
| rip_rel | output | 1 | The address is relative to the instruction pointer |
| no_base | output | 1 | No general base register |
| no_index | output | 1 | No index register |
| disp_size | output | 2 | Displacement size code |

## Verification
Every result is due exactly one clock edge after the inputs that produce it are sampled. The driver applies each set of inputs on a falling edge and records the expected values. The monitor then compares each result on the next falling edge on which `out_valid` is high. Because stimulus and sampling both happen on falling edges, results are read half a cycle after the rising edge that registered them, so no check depends on the order of processes at that edge. The reset value and the idle `out_valid` are read on a falling edge after the rising edge concerned.

// File: rtl/regspec_pkg.sv
package regspec_pkg;

  // operand size codes
  typedef enum logic [1:0] {
    OPSZ_8  = 2'd0,
    OPSZ_16 = 2'd1,
    OPSZ_32 = 2'd2,
    OPSZ_64 = 2'd3
  } opsize_e;

  // displacement size codes
  typedef enum logic [1:0] {
    DISP_NONE = 2'd0,
    DISP_8    = 2'd1,
    DISP_32   = 2'd2,
    DISP_RSVD = 2'd3
  } disp_e;

  // prefix extension bits after qualification
  typedef struct packed {
    logic w;
    logic r;
    logic x;
    logic b;
  } ext_bits_t;

endpackage

// File: rtl/regspec_prefix.sv
module regspec_prefix
  import regspec_pkg::*;
#(
  parameter logic [3:0] PFX_TAG = 4'h4
) (
  input  logic      long_mode,
  input  logic      pfx_present,
  input  logic [7:0] pfx_byte,
  output ext_bits_t ext
);
  logic hit;

  assign hit = long_mode & pfx_present & (pfx_byte[7:4] == PFX_TAG);
  assign ext = hit ? ext_bits_t'(pfx_byte[3:0]) : '0;
endmodule

// File: rtl/regspec_size.sv
module regspec_size
  import regspec_pkg::*;
(
  input  logic    byte_op,
  input  logic    opsz_ovr,
  input  logic    wide,
  output opsize_e size
);
  always_comb begin
    if (byte_op)       size = OPSZ_8;
    else if (wide)     size = OPSZ_64;
    else if (opsz_ovr) size = OPSZ_16;
    else               size = OPSZ_32;
  end
endmodule

// File: rtl/regspec_addr.sv
module regspec_addr
  import regspec_pkg::*;
#(
  parameter int FIELD_W = 3,
  localparam int NUM_W = FIELD_W + 1
) (
  input  logic               long_mode,
  input  ext_bits_t          ext,
  input  logic [1:0]         mod_f,
  input  logic [FIELD_W-1:0] rm_f,
  input  logic [FIELD_W-1:0] sib_idx,
  input  logic [FIELD_W-1:0] sib_base,
  output logic [NUM_W-1:0]   rm_num,
  output logic [NUM_W-1:0]   base_num,
  output logic [NUM_W-1:0]   idx_num,
  output logic               sib_present,
  output logic               rip_rel,
  output logic               no_base,
  output logic               no_index,
  output disp_e              disp
);
  localparam logic [FIELD_W-1:0] CODE_ESC  = FIELD_W'(4);
  localparam logic [FIELD_W-1:0] CODE_DSP  = FIELD_W'(5);
  localparam logic [NUM_W-1:0]   IDX_NONE  = {1'b0, CODE_ESC};

  logic [NUM_W-1:0] idx_full;

  assign rm_num   = {ext.b, rm_f};
  assign idx_full = {ext.x, sib_idx};

  always_comb begin
    base_num    = '0;
    idx_num     = '0;
    sib_present = 1'b0;
    rip_rel     = 1'b0;
    no_base     = 1'b1;
    no_index    = 1'b1;
    unique case (mod_f)
      2'b01:   disp = DISP_8;
      2'b10:   disp = DISP_32;
      default: disp = DISP_NONE;
    endcase
    if (mod_f != 2'b11) begin
      if (rm_f == CODE_ESC) begin
        sib_present = 1'b1;
        if (idx_full != IDX_NONE) begin
          no_index = 1'b0;
          idx_num  = idx_full;
        end
        if (mod_f == 2'b00 && sib_base == CODE_DSP) begin
          disp = DISP_32;
        end else begin
          no_base  = 1'b0;
          base_num = {ext.b, sib_base};
        end
      end else if (mod_f == 2'b00 && rm_f == CODE_DSP) begin
        rip_rel = long_mode;
        disp    = DISP_32;
      end else begin
        no_base  = 1'b0;
        base_num = {ext.b, rm_f};
      end
    end
  end
endmodule

// File: rtl/regspec_decoder.sv
module regspec_decoder
  import regspec_pkg::*;
#(
  parameter int         FIELD_W = 3,
  parameter logic [3:0] PFX_TAG = 4'h4,
  localparam int        NUM_W   = FIELD_W + 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  input  logic               long_mode,
  input  logic               pfx_present,
  input  logic [7:0]         pfx_byte,
  input  logic               opsz_ovr,
  input  logic               byte_op,
  input  logic [FIELD_W-1:0] opc_reg,
  input  logic [7:0]         modrm,
  input  logic [5:0]         sib_lo,
  output logic               out_valid,
  output logic [NUM_W-1:0]   reg_num,
  output logic [NUM_W-1:0]   rm_num,
  output logic [NUM_W-1:0]   base_num,
  output logic [NUM_W-1:0]   index_num,
  output logic [NUM_W-1:0]   opc_num,
  output logic [1:0]         op_size,
  output logic               sib_present,
  output logic               rip_rel,
  output logic               no_base,
  output logic               no_index,
  output logic [1:0]         disp_size
);
  ext_bits_t        ext;
  opsize_e          size_c;
  disp_e            disp_c;
  logic [NUM_W-1:0] rm_c, base_c, idx_c;
  logic             sib_c, rip_c, nb_c, ni_c;

  regspec_prefix #(.PFX_TAG(PFX_TAG)) u_prefix (
    .long_mode  (long_mode),
    .pfx_present(pfx_present),
    .pfx_byte   (pfx_byte),
    .ext        (ext)
  );

  regspec_size u_size (
    .byte_op (byte_op),
    .opsz_ovr(opsz_ovr),
    .wide    (ext.w),
    .size    (size_c)
  );

  regspec_addr #(.FIELD_W(FIELD_W)) u_addr (
    .long_mode  (long_mode),
    .ext        (ext),
    .mod_f      (modrm[7:6]),
    .rm_f       (modrm[FIELD_W-1:0]),
    .sib_idx    (sib_lo[2*FIELD_W-1:FIELD_W]),
    .sib_base   (sib_lo[FIELD_W-1:0]),
    .rm_num     (rm_c),
    .base_num   (base_c),
    .idx_num    (idx_c),
    .sib_present(sib_c),
    .rip_rel    (rip_c),
    .no_base    (nb_c),
    .no_index   (ni_c),
    .disp       (disp_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      reg_num     <= '0;
      rm_num      <= '0;
      base_num    <= '0;
      index_num   <= '0;
      opc_num     <= '0;
      op_size     <= '0;
      sib_present <= 1'b0;
      rip_rel     <= 1'b0;
      no_base     <= 1'b0;
      no_index    <= 1'b0;
      disp_size   <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        reg_num     <= {ext.r, modrm[2*FIELD_W-1:FIELD_W]};
        rm_num      <= rm_c;
        base_num    <= base_c;
        index_num   <= idx_c;
        opc_num     <= {ext.b, opc_reg};
        op_size     <= size_c;
        sib_present <= sib_c;
        rip_rel     <= rip_c;
        no_base     <= nb_c;
        no_index    <= ni_c;
        disp_size   <= disp_c;
      end
    end
  end
endmodule

// File: rtl/regspec_decoder_chk.sv
module regspec_decoder_chk (
  input logic       clk,
  input logic       rst,
  input logic       in_valid,
  input logic       long_mode,
  input logic       pfx_present,
  input logic [7:0] pfx_byte,
  input logic       opsz_ovr,
  input logic       byte_op,
  input logic [2:0] opc_reg,
  input logic [7:0] modrm,
  input logic [5:0] sib_lo,
  input logic       out_valid,
  input logic [3:0] reg_num,
  input logic [3:0] rm_num,
  input logic [3:0] base_num,
  input logic [3:0] index_num,
  input logic [3:0] opc_num,
  input logic [1:0] op_size,
  input logic       sib_present,
  input logic       rip_rel,
  input logic       no_base,
  input logic       no_index,
  input logic [1:0] disp_size
);
  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid); // R1

  AST_IDLE_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid); // R1

  AST_NO_EXT_OUTSIDE_LONG: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !long_mode) |=> (!reg_num[3] && !opc_num[3] && !rm_num[3])); // R2

  AST_WIDE_WINS: assert property (@(posedge clk) disable iff (rst)
    (in_valid && long_mode && pfx_present && pfx_byte[7:3] == 5'b01001 && !byte_op)
      |=> op_size == 2'd3); // R3

  AST_SIB_ON_ESCAPE: assert property (@(posedge clk) disable iff (rst)
    (in_valid && modrm[7:6] != 2'b11 && modrm[2:0] == 3'b100) |=> sib_present); // R6

  AST_RIP_DISP32: assert property (@(posedge clk) disable iff (rst)
    (out_valid && rip_rel) |-> (disp_size == 2'd2 && no_base && !sib_present)); // R8

  AST_NOBASE_ZERO: assert property (@(posedge clk) disable iff (rst)
    (out_valid && no_base) |-> base_num == 4'd0); // R11

  AST_NOINDEX_ZERO: assert property (@(posedge clk) disable iff (rst)
    (out_valid && no_index) |-> index_num == 4'd0); // R11
endmodule

bind regspec_decoder regspec_decoder_chk chk_i (.*);

// File: tb/regspec_decoder_tb_top.sv
module regspec_decoder_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic       long_mode = 1'b0;
  logic       pfx_present = 1'b0;
  logic [7:0] pfx_byte = '0;
  logic       opsz_ovr = 1'b0;
  logic       byte_op = 1'b0;
  logic [2:0] opc_reg = '0;
  logic [7:0] modrm = '0;
  logic [5:0] sib_lo = '0;
  logic       out_valid;
  logic [3:0] reg_num, rm_num, base_num, index_num, opc_num;
  logic [1:0] op_size, disp_size;
  logic       sib_present, rip_rel, no_base, no_index;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit done = 1'b0;

  logic [27:0] exp_q[$];
  string       tag_q[$];

  always #5 clk = ~clk;

  regspec_decoder dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .long_mode(long_mode),
    .pfx_present(pfx_present), .pfx_byte(pfx_byte), .opsz_ovr(opsz_ovr),
    .byte_op(byte_op), .opc_reg(opc_reg), .modrm(modrm), .sib_lo(sib_lo),
    .out_valid(out_valid), .reg_num(reg_num), .rm_num(rm_num),
    .base_num(base_num), .index_num(index_num), .opc_num(opc_num),
    .op_size(op_size), .sib_present(sib_present), .rip_rel(rip_rel),
    .no_base(no_base), .no_index(no_index), .disp_size(disp_size)
  );

  function automatic logic [27:0] model(input logic lm, input logic pp,
      input logic [7:0] pb, input logic osz, input logic bop,
      input logic [2:0] oreg, input logic [7:0] mr, input logic [5:0] sb);
    logic isx, w, r, x, b;
    logic [1:0] sz, dsp, md;
    logic [3:0] base, idx;
    logic sib, rip, nb, ni;
    isx = lm && pp && (pb[7:4] == 4'h4);        // R2
    w = isx & pb[3]; r = isx & pb[2]; x = isx & pb[1]; b = isx & pb[0];
    sz = bop ? 2'd0 : (w ? 2'd3 : (osz ? 2'd1 : 2'd2)); // R3
    md = mr[7:6];
    base = 4'd0; idx = 4'd0; sib = 0; rip = 0; nb = 1; ni = 1; dsp = 2'd0;
    if (md == 2'b01) dsp = 2'd1;
    if (md == 2'b10) dsp = 2'd2;
    if (md != 2'b11) begin
      if (mr[2:0] == 3'b100) begin               // R6
        sib = 1;
        if (!(x == 1'b0 && sb[5:3] == 3'b100)) begin ni = 0; idx = {x, sb[5:3]}; end // R7
        if (md == 2'b00 && sb[2:0] == 3'b101) dsp = 2'd2; // R9
        else begin nb = 0; base = {b, sb[2:0]}; end
      end else if (md == 2'b00 && mr[2:0] == 3'b101) begin // R8
        rip = lm; dsp = 2'd2;
      end else begin
        nb = 0; base = {b, mr[2:0]};
      end
    end
    return {{r, mr[5:3]}, {b, mr[2:0]}, base, idx, {b, oreg}, sz, sib, rip, nb, ni, dsp};
  endfunction

  task automatic drive(input logic lm, input logic pp, input logic [7:0] pb,
      input logic osz, input logic bop, input logic [2:0] oreg,
      input logic [7:0] mr, input logic [5:0] sb, input string tag);
    @(negedge clk);
    in_valid = 1'b1; long_mode = lm; pfx_present = pp; pfx_byte = pb;
    opsz_ovr = osz; byte_op = bop; opc_reg = oreg; modrm = mr; sib_lo = sb;
    exp_q.push_back(model(lm, pp, pb, osz, bop, oreg, mr, sb));
    tag_q.push_back(tag);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      logic [27:0] act;
      act = {reg_num, rm_num, base_num, index_num, opc_num, op_size,
             sib_present, rip_rel, no_base, no_index, disp_size};
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R1: result with nothing expected, actual=%h expected=none", act);
      end else begin
        logic [27:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (act !== e) begin
          errors++;
          $display("FAIL %s: actual=%h expected=%h", t, act, e);
        end
      end
    end
  end

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1'b1;
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    checks++;
    if ({out_valid, reg_num, rm_num, base_num, index_num, opc_num, op_size,
         sib_present, rip_rel, no_base, no_index, disp_size} !== 29'd0) begin
      errors++;
      $display("FAIL R1: reset outputs actual=%b expected=0", out_valid);
    end
    rst = 1'b0;

    // register form, all extensions: reg 10, rm 11 (R2 R4 R5 R3)
    drive(1, 1, 8'h4D, 0, 0, 3'd6, 8'b11_010_011, 6'd0, "R2 R4 R5");
    // W overrides 66h (R3)
    drive(1, 1, 8'h48, 1, 0, 3'd0, 8'b11_000_000, 6'd0, "R3 W-over-66");
    // 66h alone gives 16 bits (R3)
    drive(1, 0, 8'h00, 1, 0, 3'd1, 8'b11_001_001, 6'd0, "R3 16-bit");
    // byte op with W gives 8 bits (R3)
    drive(1, 1, 8'h48, 0, 1, 3'd2, 8'b11_111_000, 6'd0, "R3 byte");
    // prefix byte outside long mode is not an extension (R2)
    drive(0, 1, 8'h4F, 0, 0, 3'd7, 8'b11_111_111, 6'd0, "R2 legacy");
    // non-40h..4Fh byte ignored in long mode (R2)
    drive(1, 1, 8'h5F, 0, 0, 3'd5, 8'b11_101_101, 6'd0, "R2 non-tag");
    // opcode register with B (R4)
    drive(1, 1, 8'h41, 0, 0, 3'd3, 8'b11_000_000, 6'd0, "R4 opc");
    // SIB escape with B=1, mod 01: base 12, index 3 (R6 R10)
    drive(1, 1, 8'h41, 0, 0, 3'd0, 8'b01_000_100, 6'b011_100, "R6 R10");
    // index 100 with X=0: no index (R7 R11)
    drive(1, 1, 8'h40, 0, 0, 3'd0, 8'b10_000_100, 6'b100_000, "R7 R11 no-index");
    // index 100 with X=1: register 12 (R7)
    drive(1, 1, 8'h42, 0, 0, 3'd0, 8'b10_000_100, 6'b100_001, "R7 idx12");
    // mod 00 r/m 101 with B=1 in long mode: rip relative (R8)
    drive(1, 1, 8'h41, 0, 0, 3'd0, 8'b00_011_101, 6'd0, "R8 rip");
    // same outside long mode: no rip (R8)
    drive(0, 0, 8'h00, 0, 0, 3'd0, 8'b00_011_101, 6'd0, "R8 legacy");
    // SIB base 101 mod 00 with B=1: no base, disp32 (R9 R11)
    drive(1, 1, 8'h43, 0, 0, 3'd0, 8'b00_000_100, 6'b010_101, "R9 R11");
    // SIB base 101 mod 01 with B=1: base 13 (R9 R10)
    drive(1, 1, 8'h41, 0, 0, 3'd0, 8'b01_000_100, 6'b010_101, "R9 base13");
    // plain base, mod 10, B=1 -> base 13 disp32 (R10)
    drive(1, 1, 8'h45, 0, 0, 3'd0, 8'b10_001_101, 6'd0, "R10 disp32");
    // mod 00 plain base: no displacement (R10 R11)
    drive(1, 0, 8'h00, 0, 0, 3'd0, 8'b00_010_011, 6'd0, "R10 R11 none");

    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    // R1: idle gives no valid, and all expected results were consumed
    checks++;
    if (out_valid !== 1'b0 || exp_q.size() != 0) begin
      errors++;
      $display("FAIL R1: idle actual valid=%b pending=%0d expected valid=0 pending=0",
               out_valid, exp_q.size());
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule